// File: doc/BRIEF.md
# Test-and-Set Semaphore Flag Bank

This block holds an array of one-bit hardware semaphores, packed into words that software reaches through a simple register port with byte-lane enables. A single read is a complete test-and-set. The read returns the flags as they stand, and every flag in an enabled lane is forced to 1 by that access. A task that reads a 0 owns the semaphore. A task that reads a 1 must retry. The owner releases the semaphore by writing a 1 to its bit.

The read data comes combinationally from the flag registers during the access cycle, and the side effect lands on the closing clock edge. Two reads in consecutive cycles are therefore strictly ordered, and only one of them can win a given flag. The block assumes that the bus in front of it presents one access per cycle. It does no arbitration.

Top module: `sema_flag_bank`

## Requirements
- R1: A read with the lane enable set returns 0 for a clear flag, and that flag reads as 1 from the next cycle onward.
- R2: A read with the lane enable set returns 1 for a set flag, and the flag stays at 1.
- R3: A read returns the current value of bits in lanes whose enable is low, and it leaves those flags unchanged.
- R4: A write with the lane enable set clears every flag whose write-data bit is 1. The flag stays at 0 until an enabled read sets it.
- R5: A write-data bit of 0 leaves its flag unchanged.
- R6: A write has no effect on flags in lanes whose enable is low.
- R7: Reset, which is asynchronous and active low, clears every flag to 0. This holds on the first reset and on any later reset.
- R8: When two reads of the same flag occur in back-to-back cycles, the first returns 0 and the second returns 1.
- R9: An access changes only the word selected by `req_addr`. Every other word keeps its flags.
- R10: Flag i of word w sits at address w, data bit i. Lane k covers data bits 8k to 8k+7 and is governed only by `req_be[k]`. Lane enables are independent of one another.
- R11: Cycles with `req_valid` low change no flag, whatever the other request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write (release), 0 = read (test-and-set) |
| req_addr | input | ADDR_W | Word select |
| req_be | input | DATA_W/8 | Byte-lane enables |
| req_wdata | input | DATA_W | Write data; a 1 releases the matching flag |
| rsp_rdata | output | DATA_W | Flags of the selected word before this cycle's update; 0 when idle |

## Verification
Back-to-back reads of one flag are the main hazard. If the set were delayed by a cycle, both readers would receive 0 and would both believe they owned the semaphore. Reads with partial and zero lane enables check that a disabled lane is neither set nor reported wrongly. A design that ignored the enables would set the whole word on a single-byte read. Writes of 0, writes with all lanes disabled, and idle cycles carrying garbage data check that release happens only on an enabled 1. The bench then runs a long random mix against a behavioural model, and a reset in the middle of the run must clear every word.

// File: rtl/sema_pkg.sv
package sema_pkg;
   localparam int unsigned LANE_W = 8;

   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_e;
endpackage

// File: rtl/sema_addr_dec.sv
module sema_addr_dec #(
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned ADDR_W    = 2
) (
   input  logic                 valid_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [NUM_WORDS-1:0] sel_o
);
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
      assign sel_o[w] = valid_i && (addr_i == ADDR_W'(w));
   end
endmodule

// File: rtl/sema_word.sv
module sema_word
   import sema_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  acc_e              acc_i,
   input  logic [LANES-1:0]  be_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] flags_o
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      logic              lane_go;

      assign lane_go = hit_i && be_i[l];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (lane_go) begin
            if (acc_i == ACC_WRITE)
               lane_q <= lane_q & ~wdata_i[l*LANE_W +: LANE_W];
            else
               lane_q <= '1;
         end
      end

      assign flags_o[l*LANE_W +: LANE_W] = lane_q;

      AST_READ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_i && be_i[l] && acc_i == ACC_READ) |=> (&flags_o[l*LANE_W +: LANE_W])) // R1
         else $error("enabled read did not set lane");

      AST_OFF_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !(hit_i && be_i[l]) |=> $stable(flags_o[l*LANE_W +: LANE_W])) // R6
         else $error("disabled lane changed");

      AST_WRITE_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_i && acc_i == ACC_WRITE) |=>
            ((flags_o[l*LANE_W +: LANE_W] & ~$past(flags_o[l*LANE_W +: LANE_W])) == '0)) // R5
         else $error("write raised a flag");

      AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_i && be_i[l] && acc_i == ACC_WRITE) |=>
            ((flags_o[l*LANE_W +: LANE_W] & $past(wdata_i[l*LANE_W +: LANE_W])) == '0)) // R4
         else $error("write of 1 did not release flag");
   end
endmodule

// File: rtl/sema_rd_mux.sv
module sema_rd_mux #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 4
) (
   input  logic [NUM_WORDS-1:0]             sel_i,
   input  logic [NUM_WORDS-1:0][DATA_W-1:0] words_i,
   output logic [DATA_W-1:0]                rdata_o
);
   always_comb begin
      rdata_o = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (sel_i[w]) rdata_o = rdata_o | words_i[w];
      end
   end
endmodule

// File: rtl/sema_flag_bank.sv
module sema_flag_bank
   import sema_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NUM_WORDS = 4,
   localparam int unsigned LANES    = DATA_W / LANE_W,
   localparam int unsigned ADDR_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]  req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata
);
   if ((DATA_W % LANE_W) != 0 || DATA_W == 0) begin : g_bad_width
      $error("DATA_W must be a nonzero multiple of the lane width");
   end
   if (NUM_WORDS == 0) begin : g_bad_depth
      $error("NUM_WORDS must be at least one");
   end

   logic [NUM_WORDS-1:0]             word_sel;
   logic [NUM_WORDS-1:0][DATA_W-1:0] word_flags;
   acc_e                             acc_kind;

   assign acc_kind = req_write ? ACC_WRITE : ACC_READ;

   sema_addr_dec #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) dec_i (
      .valid_i (req_valid),
      .addr_i  (req_addr),
      .sel_o   (word_sel)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      sema_word #(.DATA_W(DATA_W)) word_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit_i   (word_sel[w]),
         .acc_i   (acc_kind),
         .be_i    (req_be),
         .wdata_i (req_wdata),
         .flags_o (word_flags[w])
      );

      AST_UNSELECTED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         !word_sel[w] |=> $stable(word_flags[w])) // R9
         else $error("unaddressed word changed");
   end

   sema_rd_mux #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) mux_i (
      .sel_i   (word_sel),
      .words_i (word_flags),
      .rdata_o (rsp_rdata)
   );

   AST_ONE_WORD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(word_sel)) // R9
      else $error("more than one word selected");

   AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(word_flags)) // R11
      else $error("idle cycle changed flags");
endmodule

// File: tb/sema_flag_bank_tb.sv
`timescale 1ns/1ps
module sema_flag_bank_tb_top;
   localparam int DW = 32;
   localparam int NW = 4;
   localparam int NB = DW / 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [NB-1:0] req_be = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] rsp_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [DW-1:0] mdl [NW];

   always #2.5 clk = ~clk;

   sema_flag_bank #(.DATA_W(DW), .NUM_WORDS(NW)) dut_i (
      .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_be, .req_wdata, .rsp_rdata
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] lane_mask(input logic [NB-1:0] be);
      logic [DW-1:0] m = '0;
      for (int k = 0; k < NB; k++) if (be[k]) m[k*8 +: 8] = 8'hff;
      return m;
   endfunction

   // one access per call; consecutive calls occupy consecutive cycles
   task automatic access(input string tag, input bit wr, input int a,
                         input logic [NB-1:0] be, input logic [DW-1:0] wd);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_be = be; req_wdata = wd;
      #1;
      if (!wr) check(tag, rsp_rdata, mdl[a]);
      if (wr) mdl[a] = mdl[a] & ~(wd & lane_mask(be));
      else    mdl[a] = mdl[a] | lane_mask(be);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0; req_write = 1'($urandom); req_addr = AW'($urandom);
         req_be = NB'($urandom); req_wdata = $urandom;
      end
   endtask

   task automatic peek_all(input string tag);
      for (int a = 0; a < NW; a++) access(tag, 1'b0, a, '0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      for (int a = 0; a < NW; a++) mdl[a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      peek_all("R7 reset state");

      access("R1 first read of lane0", 1'b0, 0, 4'b0001, '0);
      access("R8 second back-to-back read", 1'b0, 0, 4'b0001, '0);
      check("R2 set flag reads 1", rsp_rdata[7:0], 8'hff);
      access("R2 read of set flag stays", 1'b0, 0, 4'b0001, '0);
      access("R9 other word untouched", 1'b0, 1, '0, '0);
      check("R9 word1 still clear", rsp_rdata, '0);

      access("R4 release low nibble", 1'b1, 0, 4'b0001, 32'h0000_000f);
      access("R4 after release", 1'b0, 0, 4'b0000, '0);
      check("R4 lane0 now f0", rsp_rdata, 32'h0000_00f0);

      access("R5 write zeros", 1'b1, 0, 4'b1111, 32'h0000_0000);
      access("R5 after zero write", 1'b0, 0, 4'b0000, '0);
      check("R5 unchanged", rsp_rdata, 32'h0000_00f0);

      access("R6 write lanes off", 1'b1, 0, 4'b0000, 32'hffff_ffff);
      access("R6 after disabled write", 1'b0, 0, 4'b0000, '0);
      check("R6 unchanged", rsp_rdata, 32'h0000_00f0);

      access("R3 read lanes off", 1'b0, 2, 4'b0000, '0);
      access("R3 word2 still clear", 1'b0, 2, 4'b0000, '0);
      check("R3 no side effect", rsp_rdata, '0);

      access("R10 read lanes 1 and 3", 1'b0, 2, 4'b1010, '0);
      access("R10 lane map", 1'b0, 2, 4'b0000, '0);
      check("R10 lanes 1,3 set only", rsp_rdata, 32'hff00_ff00);

      idle(6);
      peek_all("R11 idle cycles change nothing");

      for (int i = 0; i < 2000; i++) begin
         access("R10 random mix", 1'($urandom), int'($urandom_range(0, NW-1)),
                NB'($urandom), $urandom);
         if ($urandom_range(0, 7) == 0) idle(1);
      end
      peek_all("R9 random end state");

      do_reset();
      peek_all("R7 mid-run reset clears");

      idle(2);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule